// File: doc/BRIEF.md
# Synchronous SRAM Core with Pipelined and Flow-Through Reads

This block is a behavioural synchronous static RAM core. Every input that sets up a cycle is sampled on the rising clock edge: address, write data, the three chip enables, the global-write and byte-write controls, and the per-lane byte selects. The stored word is split into byte lanes of 9 bits. A write can update any subset of the lanes, or all of them at once through the global write, which takes priority over the byte controls. The burst address sequence is produced outside the core, which accepts a new address on every cycle.

Read data leaves the core in one of two ways. The first is a rising-edge output register, the pipelined mode: one extra cycle of latency, but the array read has a full cycle to settle. The second bypasses that register, the flow-through mode. A static mode input picks the path. The output-drive flag follows single-cycle-deselect timing: in pipelined mode the bus is driven only in the cycle that carries a read result, and no hold cycle follows. An asynchronous active-low output enable gates the outputs without a clock. A sleep input blocks new commands, turns the outputs off and keeps the stored contents.

The shared data bus is modelled as a separate input bus, a separate output bus and an output-drive flag. A tri-state pad at chip level would combine them.

Top module: `sync_sram_core`

## Requirements
- R1: A cycle is selected only when `ce_a_n` is 0, `ce_b` is 1 and `ce_c_n` is 0 at the capturing edge. Any other combination performs no write, and the cycle it starts does not drive the outputs.
- R2: With `gwr_n` = 0 in a selected cycle, all lanes of the addressed word take `din`, whatever `bwr_n` and `lane_n` are.
- R3: With `gwr_n` = 1 and `bwr_n` = 0 in a selected cycle, lane i (bits [9i+8:9i]) is written only if `lane_n[i]` = 0. Other lanes keep their contents. A write cycle never drives the outputs.
- R4: A selected cycle with `gwr_n` = 1 and `bwr_n` = 1 is a read of the addressed word.
- R5: With `pipe_mode` = 0 (flow-through), a read captured at edge k puts its data on `dout` with `dout_en` = 1 right after edge k. Back-to-back reads deliver one word per cycle.
- R6: With `pipe_mode` = 1 (pipelined), a read captured at edge k appears on `dout` right after edge k+1. Back-to-back reads deliver one word per cycle.
- R7: Single-cycle deselect: `dout_en` falls in the first cycle after the last read result. In pipelined mode, a non-read captured at edge k+1 after a read at edge k leaves `dout_en` low after edge k+2. In flow-through mode, it is low right after the non-read is captured.
- R8: `oe_n` = 1 forces `dout_en` to 0 at once, with no clock edge. Returning `oe_n` to 0 restores the drive in the same cycle.
- R9: While `sleep` = 1, `dout_en` is 0 and captured commands have no effect, so a write presented during sleep leaves the array unchanged. A command presented with `sleep` = 0 on the first edge after release executes normally.
- R10: A read of the address written in the immediately preceding cycle returns the newly written data, in both modes.
- R11: `dout` is all zeros whenever `dout_en` is 0.
- R12: While `rst_n` is low, the command stages are cleared and `dout_en` is 0. The array contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control stages |
| pipe_mode | input | 1 | Static mode: 1 pipelined, 0 flow-through |
| sleep | input | 1 | Low-power request, active high |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| addr | input | ADDR_W | Word address |
| gwr_n | input | 1 | Global write of all lanes, active low |
| bwr_n | input | 1 | Byte-write enable, active low |
| lane_n | input | LANES | Per-lane byte select, active low |
| din | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_en | output | 1 | Output-drive flag |

## Verification
The bench builds the core with its defaults: 4 address bits and 2 lanes of 9 bits, which gives 16 words of 18 bits. At that size the sweeps can cover every address in both read modes, every address with each of the four lane-select patterns, and all eight chip-enable combinations. Each expected word is computed arithmetically from the address and the lane pattern and merged lane by lane into a bench-side copy of the array. The short depth also puts the mode-specific edges in direct reach: read-then-write turnaround, deselect turn-off, asynchronous gating, and the first command after sleep.

// File: rtl/sync_sram_core.sv
module sync_sram_core #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pipe_mode,
  input  logic                    sleep,
  input  logic                    ce_a_n,
  input  logic                    ce_b,
  input  logic                    ce_c_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    gwr_n,
  input  logic                    bwr_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  wire             chosen  = ~ce_a_n & ce_b & ~ce_c_n;
  wire             accept  = chosen & ~sleep;
  wire             wr_cmd  = ~gwr_n | ~bwr_n;
  wire [LANES-1:0] hit     = {LANES{~gwr_n}} | ({LANES{~bwr_n}} & ~lane_n);

  logic              c_rd;
  logic [LANES-1:0]  c_lanes;
  logic [ADDR_W-1:0] c_addr;
  logic [DATA_W-1:0] c_din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_rd    <= 1'b0;
      c_lanes <= '0;
      c_addr  <= '0;
      c_din   <= '0;
    end else begin
      c_rd    <= accept & ~wr_cmd;
      c_lanes <= accept ? hit : '0;
      c_addr  <= addr;
      c_din   <= din;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (c_lanes[i]) mem[c_addr][i*LANE_W +: LANE_W] <= c_din[i*LANE_W +: LANE_W];
  end

  wire [DATA_W-1:0] rd_word = mem[c_addr];

  logic [DATA_W-1:0] out_q;
  logic              drv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      drv_q <= 1'b0;
    end else begin
      drv_q <= c_rd;
      if (c_rd) out_q <= rd_word;
    end
  end

  assign dout_en = ~oe_n & ~sleep & (pipe_mode ? drv_q : c_rd);
  assign dout    = dout_en ? (pipe_mode ? out_q : rd_word) : '0;

  assert_desel_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ce_a_n && ce_b && !ce_c_n) |=> (!c_rd && c_lanes == '0));

  assert_global_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (c_lanes == '1) |=> (mem[$past(c_addr)] == $past(c_din)));

  for (genvar g = 0; g < LANES; g++) begin : g_keep
    assert_lane_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (c_lanes != '0 && !c_lanes[g]) |=>
        (mem[$past(c_addr)][g*LANE_W +: LANE_W] == $past(rd_word[g*LANE_W +: LANE_W])));
  end

  assert_pipe_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && dout_en) |-> $past(c_rd));

  assert_scd_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && !$past(c_rd)) |-> !dout_en);

  assert_sleep_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!c_rd && c_lanes == '0));
endmodule

// File: tb/tb_sync_sram_core.sv
`timescale 1ns/100ps
module tb_sync_sram_core;
  logic clk = 0, rst_n = 0, pipe_mode = 0, sleep = 0;
  logic ce_a_n = 1, ce_b = 1, ce_c_n = 0;
  logic [3:0] addr = 0;
  logic gwr_n = 1, bwr_n = 1, oe_n = 0;
  logic [1:0] lane_n = 2'b11;
  logic [17:0] din = 0;
  logic [17:0] dout;
  logic dout_en;

  sync_sram_core dut (.clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .sleep(sleep),
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .addr(addr), .gwr_n(gwr_n),
    .bwr_n(bwr_n), .lane_n(lane_n), .din(din), .oe_n(oe_n), .dout(dout), .dout_en(dout_en));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [17:0] model [16];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] pat(input int a, input int s);
    return 18'((a * 4661 + s * 1237 + 77) & 18'h3ffff);
  endfunction

  task automatic drive(input bit an, input bit b, input bit cn, input int a,
                       input bit gw, input bit bw, input logic [1:0] ln, input logic [17:0] d);
    ce_a_n = an; ce_b = b; ce_c_n = cn; addr = 4'(a);
    gwr_n = gw; bwr_n = bw; lane_n = ln; din = d;
    @(posedge clk); #1;
  endtask

  task automatic rd(input int a);  drive(0, 1, 0, a, 1, 1, 2'b11, 18'h0); endtask
  task automatic nop();            drive(1, 1, 0, 0, 1, 1, 2'b11, 18'h0); endtask
  task automatic gw(input int a, input logic [17:0] d, input logic [1:0] ln, input bit bw);
    drive(0, 1, 0, a, 0, bw, ln, d);
    model[a] = d;
  endtask
  task automatic bwr(input int a, input logic [1:0] ln, input logic [17:0] d);
    drive(0, 1, 0, a, 1, 0, ln, d);
    for (int i = 0; i < 2; i++)
      if (!ln[i]) model[a][i*9 +: 9] = d[i*9 +: 9];
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset dout_en", 32'(dout_en), 0);
    chk("R12 reset dout", 32'(dout), 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;

    // flow-through: global writes ignore byte controls (R2)
    for (int a = 0; a < 16; a++) gw(a, pat(a, 0), 2'(a), a[2]);
    for (int a = 0; a < 16; a++) begin
      rd(a);
      chk("R5 R2 flow read data", 32'(dout), 32'(model[a]));
      chk("R5 R4 flow drive", 32'(dout_en), 1);
    end
    nop();
    chk("R7 flow off after deselect", 32'(dout_en), 0);
    chk("R11 dout zero undriven", 32'(dout), 0);

    // byte-lane sweep (R3)
    for (int a = 0; a < 16; a++)
      for (int l = 0; l < 4; l++) begin
        bwr(a, 2'(l), pat(a, l + 1));
        chk("R3 write no drive", 32'(dout_en), 0);
      end
    for (int a = 0; a < 16; a++) begin
      rd(a);
      chk("R3 lane merge", 32'(dout), 32'(model[a]));
    end

    // read right after write (R10)
    for (int a = 0; a < 16; a++) begin
      gw(a, ~pat(a, 9), 2'b11, 1);
      rd(a);
      chk("R10 flow read-after-write", 32'(dout), 32'(model[a]));
    end

    // chip enable sweep (R1)
    for (int c = 0; c < 8; c++) begin
      drive(c[0], c[1], c[2], 9, 0, 1, 2'b11, 18'(256 + c));
      if (c == 2) model[9] = 18'(256 + c);
      rd(9);
      chk("R1 enable write gate", 32'(dout), 32'(model[9]));
      drive(c[0], c[1], c[2], 9, 1, 1, 2'b11, 18'h0);
      chk("R1 enable read drive", 32'(dout_en), 32'(c == 2));
    end

    // async output enable (R8)
    rd(4);
    chk("R8 driven", 32'(dout_en), 1);
    oe_n = 1; #0.5;
    chk("R8 oe off", 32'(dout_en), 0);
    chk("R11 oe off zero", 32'(dout), 0);
    oe_n = 0; #0.5;
    chk("R8 oe back", 32'(dout), 32'(model[4]));

    // sleep (R9)
    rd(4);
    sleep = 1; #0.5;
    chk("R9 sleep off", 32'(dout_en), 0);
    gw(4, 18'h3ffff, 2'b11, 1);
    model[4] = ~pat(4, 9);
    rd(4);
    chk("R9 sleep read blocked", 32'(dout_en), 0);
    sleep = 0;
    rd(4);
    chk("R9 resume and retain", 32'(dout), 32'(model[4]));
    chk("R9 resume drive", 32'(dout_en), 1);

    // pipelined mode (R6, R7, R10)
    nop();
    pipe_mode = 1;
    nop();
    rd(0);
    chk("R6 not yet valid", 32'(dout_en), 0);
    for (int a = 1; a < 16; a++) begin
      rd(a);
      chk("R6 pipe data", 32'(dout), 32'(model[a-1]));
      chk("R6 pipe drive", 32'(dout_en), 1);
    end
    nop();
    chk("R6 last beat", 32'(dout), 32'(model[15]));
    nop();
    chk("R7 scd off", 32'(dout_en), 0);

    rd(2);
    begin
      logic [17:0] old;
      old = model[2];
      gw(2, pat(2, 33), 2'b11, 1);
      chk("R7 read before write", 32'(dout), 32'(old));
    end
    rd(2);
    chk("R7 write gives no drive", 32'(dout_en), 0);
    nop();
    chk("R10 pipe read-after-write", 32'(dout), 32'(model[2]));

    rd(6);
    sleep = 1;
    nop();
    chk("R9 pipe sleep off", 32'(dout_en), 0);
    sleep = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule